// File: doc/BRIEF.md
# Hierarchical Interrupt Status Controller

This block gathers pending flags from a parameterised set of interrupt lines (256 by default). The lines are grouped eight to a block, and the blocks are grouped eight to a master. Each line has its own trigger logic. That logic can catch a rising edge, a falling edge, both edges, a high level or a low level. It holds a pending flag until software clears it.

Software reaches the block through a byte-wide register port with an address, read and write strobes and write data. It walks a three-level tree:

- The root register shows which masters have work.
- A master register shows which blocks have work.
- A block's pending bits, its live input levels and its per-line trigger settings are reached indirectly, after the block number has been written to a block-select register.

A single summary output tells the host that something in the tree is pending.

Nine byte registers sit at consecutive addresses starting at `BASE_ADDR`:

| Offset | Register |
|---|---|
| +0 | root |
| +1 to +4 | master 0 to master 3 |
| +5 | block select |
| +6 | pending bits of the selected block |
| +7 | trigger configuration (write-only) |
| +8 | live levels of the selected block |

Line n lives in block n/8 at bit n%8. Block b lives in master b/8 at bit b%8.

Top module: `hier_irq_ctrl`

## Requirements
- R1: After reset every pending flag is clear, block select reads 0, `irq_summary` is low, and every line has both edge masks set, so no input activity makes a line pending.
- R2: Root bit 0 always reads 0, and root bit m+1 is 1 exactly when master m has any pending line. `irq_summary` is 1 exactly when any root master bit is 1.
- R3: Master register m (offset 1+m) has bit j set exactly when block 8m+j holds at least one pending line.
- R4: A write to offset 5 stores the block number, which reads back at offset 5. A read of offset 6 returns the eight pending flags of the selected block, with line n at bit n%8 of block n/8.
- R5: A read of offset 8 returns the current input levels of the selected block's eight lines.
- R6: A write to offset 7 with bit 7 at 0 changes neither configuration nor pending state.
- R7: A write to offset 7 with bit 7 at 1 updates line {block select, wdata[6:4]}. Bit 0 selects level mode, bit 1 masks the falling edge and bit 2 masks the rising edge. In edge mode an unmasked edge sets the pending flag.
- R8: In level mode the pending flag is set while the input is high with the rising mask clear, or low with the falling mask clear.
- R9: A committed configuration write with bit 3 at 1 clears that line's pending flag. The clear wins over a trigger in the same cycle.
- R10: Read data appears in the cycle after the read strobe and is 0 otherwise. Offset 7, and any address outside offsets 0 to 8, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_LINES | Synchronous interrupt input levels |
| reg_addr | input | ADDR_W | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_summary | output | 1 | High while any line is pending |

## Verification
Directed cases first arm a single rising-edge line, then a low-level line in the last master. This shows whether the root offset, the master index and the bit position inside the selected block are each mapped correctly. A clear that is written without the commit bit, followed by a committed clear, separates the commit gating from the clear action. After that, a random mix of line levels, configuration writes with and without commit, block selections and reads across the whole window (plus addresses just outside it) is compared against a bench model of the tree. Edge and level detection, clear priority and the read-back of unused offsets are thereby exercised together in many combinations.

// File: rtl/hic_pkg.sv
package hic_pkg;
   localparam int REG_W       = 8;
   localparam int LINES_PER_B = 8;
   localparam int BLKS_PER_M  = 8;
   // register offsets from the window base
   localparam int OFS_ROOT    = 0;
   localparam int OFS_MST0    = 1;
   localparam int OFS_BSEL    = 5;
   localparam int OFS_PEND    = 6;
   localparam int OFS_CFG     = 7;
   localparam int OFS_LIVE    = 8;
   localparam int OFS_LAST    = 8;
   localparam int MAX_MASTERS = 4;
   // configuration write fields
   localparam int CFG_COMMIT  = 7;
   localparam int CFG_CLR     = 3;

   typedef struct packed {
      logic mask_rise;   // bit 2
      logic mask_fall;   // bit 1
      logic lvl_mode;    // bit 0
   } line_cfg_t;

   localparam line_cfg_t CFG_RESET = '{mask_rise: 1'b1, mask_fall: 1'b1, lvl_mode: 1'b0};
endpackage

// File: rtl/hic_line_trig.sv
module hic_line_trig
   import hic_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lvl_in,
   input  logic      cfg_we,
   input  line_cfg_t cfg_new,
   input  logic      clr_req,
   output logic      pend,
   output line_cfg_t cfg_q
);
   logic prev_q;
   logic hit;

   always_comb begin
      if (cfg_q.lvl_mode)
         hit = (lvl_in & ~cfg_q.mask_rise) | (~lvl_in & ~cfg_q.mask_fall);
      else
         hit = (lvl_in & ~prev_q & ~cfg_q.mask_rise) |
               (~lvl_in & prev_q & ~cfg_q.mask_fall);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend   <= 1'b0;
         cfg_q  <= CFG_RESET;
      end else begin
         prev_q <= lvl_in;
         if (cfg_we)
            cfg_q <= cfg_new;
         if (cfg_we && clr_req)
            pend <= 1'b0;
         else if (hit)
            pend <= 1'b1;
      end
   end

   // R9: a committed clear leaves the flag low in the next cycle
   assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && clr_req) |=> !pend);

   // R7: a line with both masks set never becomes pending
   assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.mask_rise && cfg_q.mask_fall && !cfg_we && !pend) |=> !pend);
endmodule

// File: rtl/hic_status_tree.sv
module hic_status_tree
   import hic_pkg::*;
#(
   parameter int NUM_BLKS    = 32,
   parameter int NUM_MASTERS = 4
) (
   input  logic [NUM_BLKS*LINES_PER_B-1:0]   pend,
   output logic [NUM_MASTERS-1:0][REG_W-1:0] mst_bits,
   output logic [REG_W-1:0]                  root
);
   logic [NUM_BLKS-1:0]    blk_any;
   logic [NUM_MASTERS-1:0] mst_any;

   for (genvar b = 0; b < NUM_BLKS; b++) begin : g_blk
      assign blk_any[b] = |pend[b*LINES_PER_B +: LINES_PER_B];
   end

   for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
      for (genvar j = 0; j < BLKS_PER_M; j++) begin : g_bit
         if (m*BLKS_PER_M + j < NUM_BLKS) begin : g_used
            assign mst_bits[m][j] = blk_any[m*BLKS_PER_M + j];
         end else begin : g_pad
            assign mst_bits[m][j] = 1'b0;
         end
      end
      assign mst_any[m] = |mst_bits[m];
   end

   always_comb begin
      root = '0;
      root[NUM_MASTERS:1] = mst_any;
   end
endmodule

// File: rtl/hier_irq_ctrl.sv
module hier_irq_ctrl
   import hic_pkg::*;
#(
   parameter int NUM_LINES = 256,
   parameter int ADDR_W    = 8,
   parameter int BASE_ADDR = 'h40
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_rd,
   input  logic                 reg_wr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   output logic                 irq_summary
);
   localparam int NUM_BLKS    = NUM_LINES / LINES_PER_B;
   localparam int NUM_MASTERS = (NUM_BLKS + BLKS_PER_M - 1) / BLKS_PER_M;
   localparam int BSEL_W      = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1;
   localparam int LINE_W      = BSEL_W + 3;
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BASE_ADDR + OFS_LAST);

   if (NUM_LINES % LINES_PER_B != 0 || NUM_LINES < LINES_PER_B) begin : g_bad_lines
      $error("NUM_LINES must be a nonzero multiple of eight");
   end
   if (NUM_MASTERS > MAX_MASTERS) begin : g_bad_masters
      $error("at most four masters fit the register window");
   end
   if (BASE_ADDR + OFS_LAST >= (1 << ADDR_W)) begin : g_bad_base
      $error("register window does not fit the address width");
   end

   logic [BSEL_W-1:0]                  blk_sel;
   logic [NUM_LINES-1:0]               pend;
   logic [3*NUM_LINES-1:0]             cfg_flat;
   logic [NUM_MASTERS-1:0][REG_W-1:0]  mst_bits;
   logic [REG_W-1:0]                   root;
   logic                               in_win;
   logic [3:0]                         ofs;
   logic                               wr_cfg;
   logic [LINE_W-1:0]                  line_sel;
   logic [REG_W-1:0]                   rd_mux;

   assign in_win   = (reg_addr >= BASE_A) && (reg_addr <= LAST_A);
   assign ofs      = 4'(reg_addr - BASE_A);
   assign wr_cfg   = reg_wr && in_win && (ofs == 4'(OFS_CFG)) && reg_wdata[CFG_COMMIT];
   assign line_sel = {blk_sel, reg_wdata[6:4]};

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      hic_line_trig u_trig (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl_in  (irq_lines[n]),
         .cfg_we  (wr_cfg && (int'(line_sel) == n)),
         .cfg_new (line_cfg_t'(reg_wdata[2:0])),
         .clr_req (reg_wdata[CFG_CLR]),
         .pend    (pend[n]),
         .cfg_q   (cfg_flat[3*n +: 3])
      );
   end

   hic_status_tree #(
      .NUM_BLKS    (NUM_BLKS),
      .NUM_MASTERS (NUM_MASTERS)
   ) u_tree (
      .pend     (pend),
      .mst_bits (mst_bits),
      .root     (root)
   );

   assign irq_summary = |root;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         blk_sel <= '0;
      else if (reg_wr && in_win && ofs == 4'(OFS_BSEL))
         blk_sel <= reg_wdata[BSEL_W-1:0];
   end

   always_comb begin
      int unsigned base;
      base   = int'(blk_sel) * LINES_PER_B;
      rd_mux = '0;
      if (in_win) begin
         case (int'(ofs))
            OFS_ROOT: rd_mux = root;
            OFS_BSEL: rd_mux = REG_W'(blk_sel);
            OFS_PEND: if (base < NUM_LINES) rd_mux = pend[base +: LINES_PER_B];
            OFS_LIVE: if (base < NUM_LINES) rd_mux = irq_lines[base +: LINES_PER_B];
            default: begin
               for (int m = 0; m < NUM_MASTERS; m++)
                  if (int'(ofs) == OFS_MST0 + m) rd_mux = mst_bits[m];
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reg_rdata <= '0;
      else
         reg_rdata <= reg_rd ? rd_mux : '0;
   end

   // R10: no read strobe means zero read data next cycle
   assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> (reg_rdata == '0));

   // R2: summary output agrees with the per-line pending flags
   assert_summary_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_summary == (|pend));

   // R6: an uncommitted configuration write leaves configuration unchanged
   assert_cfg_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && in_win && ofs == 4'(OFS_CFG) && !reg_wdata[CFG_COMMIT]) |=> $stable(cfg_flat));

   // R4: block select only moves on a write to its own offset
   assert_bsel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && in_win && ofs == 4'(OFS_BSEL)) |=> $stable(blk_sel));
endmodule

// File: tb/tb_hier_irq_ctrl.sv
module tb_hier_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NL   = 256;
   localparam int BASE = 'h40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] lines = '0;
   logic [7:0]    addr = '0;
   logic          rd = 1'b0;
   logic          wr = 1'b0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic          irq;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   hier_irq_ctrl #(.NUM_LINES(NL), .ADDR_W(8), .BASE_ADDR(BASE)) dut (
      .clk(clk), .rst_n(rst_n), .irq_lines(lines), .reg_addr(addr),
      .reg_rd(rd), .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rdata),
      .irq_summary(irq));

   always #(CLK_PERIOD/2) clk = ~clk;

   // bench model, built from the requirements
   logic [NL-1:0] m_pend, m_prev;
   logic [2:0]    m_cfg [NL];   // {mask_rise, mask_fall, lvl_mode}
   logic [4:0]    m_bsel;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pend <= '0; m_prev <= '0; m_bsel <= '0;
         for (int n = 0; n < NL; n++) m_cfg[n] <= 3'b110;
      end else begin
         for (int n = 0; n < NL; n++) begin
            logic t, sel, cw;
            logic [2:0] c;
            c = m_cfg[n];
            if (c[0]) t = (lines[n] & ~c[2]) | (~lines[n] & ~c[1]);
            else      t = (lines[n] & ~m_prev[n] & ~c[2]) | (~lines[n] & m_prev[n] & ~c[1]);
            sel = (int'({m_bsel, wdata[6:4]}) == n);
            cw  = wr && addr == 8'(BASE + 7) && wdata[7] && sel;
            if (cw && wdata[3]) m_pend[n] <= 1'b0;
            else if (t)         m_pend[n] <= 1'b1;
            if (cw) m_cfg[n] <= wdata[2:0];
         end
         m_prev <= lines;
         if (wr && addr == 8'(BASE + 5)) m_bsel <= wdata[4:0];
      end
   end

   function automatic logic [7:0] exp_reg(logic [7:0] a);
      logic [7:0] r;
      int o;
      r = '0;
      if (int'(a) < BASE || int'(a) > BASE + 8) return r;
      o = int'(a) - BASE;
      case (o)
         0: for (int m = 0; m < 4; m++) r[m+1] = |m_pend[m*64 +: 64];
         1, 2, 3, 4: for (int j = 0; j < 8; j++) r[j] = |m_pend[((o-1)*8 + j)*8 +: 8];
         5: r = {3'b000, m_bsel};
         6: r = m_pend[int'(m_bsel)*8 +: 8];
         8: r = lines[int'(m_bsel)*8 +: 8];
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr_reg(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(logic [7:0] a, output logic [7:0] d, output logic [7:0] e);
      @(negedge clk);
      addr = a; rd = 1'b1;
      e = exp_reg(a);
      @(negedge clk);
      rd = 1'b0;
      d = rdata;
   endtask

   task automatic rd_chk(string req, logic [7:0] a, logic [7:0] lit);
      logic [7:0] d, e;
      rd_reg(a, d, e);
      check(req, d, lit);
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] d, e;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R1 reset state
      check("R1 irq", {7'd0, irq}, 8'h00);
      rd_chk("R1 root", 8'(BASE), 8'h00);
      rd_chk("R1 bsel", 8'(BASE + 5), 8'h00);
      lines[3] = 1'b1; step(); step();
      rd_chk("R1 masked line", 8'(BASE + 6), 8'h00);
      check("R10 idle rdata", rdata, 8'h00);
      // R7 rising edge on line 10 (block 1 bit 2)
      wr_reg(8'(BASE + 5), 8'd1);
      wr_reg(8'(BASE + 7), 8'h80 | 8'h20 | 8'h02);
      lines[10] = 1'b1; step();
      rd_chk("R7 rising edge", 8'(BASE + 6), 8'h04);
      rd_chk("R3 master0", 8'(BASE + 1), 8'h02);
      rd_chk("R2 root", 8'(BASE), 8'h02);
      check("R2 irq high", {7'd0, irq}, 8'h01);
      // R9 clear
      wr_reg(8'(BASE + 7), 8'h80 | 8'h20 | 8'h02 | 8'h08);
      step();
      rd_chk("R9 cleared", 8'(BASE + 6), 8'h00);
      check("R2 irq low", {7'd0, irq}, 8'h00);
      // R6 uncommitted clear ignored
      lines[10] = 1'b0; step(); lines[10] = 1'b1; step();
      wr_reg(8'(BASE + 7), 8'h28);
      rd_chk("R6 no commit", 8'(BASE + 6), 8'h04);
      wr_reg(8'(BASE + 7), 8'h2A | 8'h80);
      // R8 low level on line 200 (block 25 bit 0, master 3)
      wr_reg(8'(BASE + 5), 8'd25);
      rd_chk("R4 bsel readback", 8'(BASE + 5), 8'd25);
      wr_reg(8'(BASE + 7), 8'h85);
      step();
      rd_chk("R8 low level", 8'(BASE + 6), 8'h01);
      rd_chk("R3 master3", 8'(BASE + 4), 8'h02);
      rd_chk("R2 root m3", 8'(BASE), 8'h10);
      lines[201] = 1'b1; lines[207] = 1'b1;
      rd_chk("R5 live", 8'(BASE + 8), 8'h82);
      rd_chk("R10 cfg reads zero", 8'(BASE + 7), 8'h00);
      rd_chk("R10 above window", 8'(BASE + 9), 8'h00);
      rd_chk("R10 below window", 8'(BASE - 1), 8'h00);
      // random phase checked against the model (R2..R10)
      for (int it = 0; it < 1500; it++) begin
         int k;
         k = $urandom % 8;
         if (k == 0) begin
            @(negedge clk);
            for (int w = 0; w < 8; w++) lines[w*32 +: 32] = $urandom;
         end else if (k == 1) begin
            wr_reg(8'(BASE + 5), 8'($urandom % 32));
         end else if (k == 2) begin
            logic [7:0] v;
            v = 8'($urandom);
            if ($urandom % 4 == 0) v[7] = 1'b0; else v[7] = 1'b1;
            wr_reg(8'(BASE + 7), v);
         end else begin
            logic [7:0] a;
            a = 8'(BASE - 1 + int'($urandom % 11));
            rd_reg(a, d, e);
            check("R2-tree/R4/R5/R10 random read", d, e);
         end
         check("R2 random irq", {7'd0, irq}, {7'd0, |m_pend});
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule